// File: doc/BRIEF.md
# Interrupt Controller Register Interface

This block is the 32-bit memory-mapped front end of an interrupt domain. It takes a single-beat request, checks that the access is a word-sized and word-aligned hit on a mapped register, and turns it into one command for an external per-source state store. The store holds mode, target, pending, enable and input state, and it answers reads combinationally. Only two registers live in the block itself: the domain interrupt-enable bit and the last generated-message word. The block replies one cycle after the request, with read data or an error flag.

Registers that act on pending or enable bits come in three forms. Bitmap words act on up to 32 sources at once. By-number registers act on one source, and one of them byte-swaps the number before use. The clear-type bitmaps do not read back what they write: clear-pending returns the rectified input levels and clear-enable returns zero. Each accepted write is followed by a one-cycle request to rescan all sources for enabled-and-pending delivery. A write to the message register also emits one message descriptor.

Top module: `irq_reg_if`

## Requirements
- R1: A request is rejected when bus_size is not 2 (4 bytes), when bus_addr[1:0] is not 0, or when the offset maps to no register. In every case rsp_err=1 and rsp_rdata=0 one cycle after the request, with no store command, no scan_req and no register change.
- R2: Store command codes on st_cmd are: 0 idle, 1 read mode, 2 read target, 3 read pending word, 4 read enable word, 5 read rectified-input word, 6 write mode, 7 write target, 8 set pending, 9 clear pending, 10 set enable, 11 clear enable. The command is driven combinationally during the request cycle only, and only for an accepted access. Read data from st_rdata is returned in rsp_rdata on the next cycle.
- R3: The domain register at offset 0x0000 keeps only wdata bit 8 as the enable (output dom_ie). It reads as 0x80000004 OR (dom_ie << 8).
- R4: Mode words at 0x0004 + 4*(k-1), for k from 1 to NUM_IRQ-1, use command 1 or 6 with st_index=k. The written value becomes 0 if wdata bit 10 is set, and wdata[2:0] otherwise.
- R5: Target words at 0x3004 + 4*(k-1), for k from 1 to NUM_IRQ-1, use command 2 or 7 with st_index=k. The written value is wdata AND 0xFFFFF7FF, which keeps the identity bits 10:0, the guest index bits 17:12 and the hart index bits 31:18.
- R6: Set-pending bitmap words at 0x1C00 + 4*w and set-enable bitmap words at 0x1E00 + 4*w, for w below ceil(NUM_IRQ/32), write command 8 or 10 with st_index=w. The mask is wdata with the bits for source 0 and for sources at or above NUM_IRQ cleared. Reads use command 3 or 4.
- R7: Clear-pending bitmap words at 0x1D00 + 4*w write command 9, and a read returns the rectified-input word (command 5). Clear-enable bitmap words at 0x1F00 + 4*w write command 11, and a read returns 0 with no store command.
- R8: By-number registers take a source number n from wdata: set-pending at 0x1CDC and 0x2000, clear-pending at 0x1DDC, set-enable at 0x1EDC, clear-enable at 0x1FDC. If n is between 1 and NUM_IRQ-1, a write issues the matching command with st_index=n>>5 and mask 1<<n[4:0]. Any other n issues no command, but the write is still accepted. Reads return 0.
- R9: At 0x2004 the written word is byte-reversed before use as the set-pending source number.
- R10: A write to 0x3000 stores wdata with bits 17:12 cleared, and reads return that value. On the next cycle msg_valid pulses for one cycle with msg_hart=wdata[31:18] and msg_eiid=wdata[10:0].
- R11: Every accepted write, and nothing else, pulses scan_req for one cycle, aligned with its response.
- R12: After reset: rsp_valid, rsp_err, scan_req, msg_valid and dom_ie are 0, and the message register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Request strobe, one cycle per access |
| bus_write | input | 1 | 1 write, 0 read |
| bus_size | input | 2 | Access size code, 2 means 4 bytes |
| bus_addr | input | ADDR_W | Byte offset in the register space |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Access rejected |
| rsp_rdata | output | 32 | Read data |
| st_cmd | output | 4 | Store command code |
| st_index | output | IDX_W | Source number or bitmap word index |
| st_wdata | output | 32 | Store write value or bit mask |
| st_rdata | input | 32 | Store read data for the current command |
| dom_ie | output | 1 | Domain delivery enable |
| scan_req | output | 1 | Rescan request after an accepted write |
| msg_valid | output | 1 | Message descriptor strobe |
| msg_hart | output | 14 | Message hart index |
| msg_eiid | output | 11 | Message identity |

## Verification
A wrong decode shows up in the request cycle itself, as the wrong command code, index or mask toward the store. A wrong read path, an error flag set or missing, or a scan request after a rejected access shows up on the response one cycle later. Mistakes in the domain and message registers show on dom_ie and on the message outputs in the cycle after the write, and in the value returned by the next read of that register. The per-source masking at window and number boundaries, including the byte-swapped alias, only shows in the mask bits of the exact access that touches them, so the stimulus covers the edges of each window.

// File: rtl/irq_reg_if.sv
module irq_reg_if #(
  parameter int NUM_IRQ = 64,
  parameter int ADDR_W  = 14,
  parameter int IDX_W   = $clog2(NUM_IRQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic [3:0]        st_cmd,
  output logic [IDX_W-1:0]  st_index,
  output logic [31:0]       st_wdata,
  input  logic [31:0]       st_rdata,
  output logic              dom_ie,
  output logic              scan_req,
  output logic              msg_valid,
  output logic [13:0]       msg_hart,
  output logic [10:0]       msg_eiid
);
  localparam int NW = (NUM_IRQ + 31) / 32;
  localparam int CFG_END = 4 + 4 * (NUM_IRQ - 1);
  localparam int TGT_END = 32'h3004 + 4 * (NUM_IRQ - 1);

  logic [31:0] a, num, rd, wd, genmsi_q;
  logic [31:0] idx32;
  logic [3:0]  cmd;
  logic        hit, num_ok, err, acc_ok, is_dom, is_msi;

  function automatic logic [31:0] word_mask(input logic [31:0] w);
    logic [31:0] m;
    for (int b = 0; b < 32; b++) begin
      m[b] = ((w * 32 + b) >= 1) && ((w * 32 + b) < NUM_IRQ);
    end
    return m;
  endfunction

  function automatic logic in_map(input logic [31:0] x, input int base);
    return (x >= base) && (x < base + 4 * NW);
  endfunction

  assign a      = 32'(bus_addr);
  assign num    = (a == 32'h2004) ? {bus_wdata[7:0], bus_wdata[15:8], bus_wdata[23:16], bus_wdata[31:24]}
                                  : bus_wdata;
  assign num_ok = (num >= 1) && (num < NUM_IRQ);
  assign is_dom = (a == 32'h0000);
  assign is_msi = (a == 32'h3000);

  always_comb begin
    cmd = 4'd0; idx32 = '0; wd = '0; rd = '0; hit = 1'b1;
    if (is_dom) begin
      rd = 32'h8000_0004 | {23'd0, dom_ie, 8'd0};
    end else if (a >= 4 && a < CFG_END) begin
      idx32 = ((a - 4) >> 2) + 1;
      cmd   = bus_write ? 4'd6 : 4'd1;
      wd    = bus_wdata[10] ? 32'd0 : {29'd0, bus_wdata[2:0]};
      rd    = st_rdata;
    end else if (a >= 32'h3004 && a < TGT_END) begin
      idx32 = ((a - 32'h3004) >> 2) + 1;
      cmd   = bus_write ? 4'd7 : 4'd2;
      wd    = bus_wdata & 32'hFFFF_F7FF;
      rd    = st_rdata;
    end else if (in_map(a, 32'h1C00)) begin
      idx32 = (a - 32'h1C00) >> 2;
      cmd   = bus_write ? 4'd8 : 4'd3;
      wd    = bus_wdata & word_mask(idx32);
      rd    = st_rdata;
    end else if (in_map(a, 32'h1D00)) begin
      idx32 = (a - 32'h1D00) >> 2;
      cmd   = bus_write ? 4'd9 : 4'd5;
      wd    = bus_wdata & word_mask(idx32);
      rd    = st_rdata;
    end else if (in_map(a, 32'h1E00)) begin
      idx32 = (a - 32'h1E00) >> 2;
      cmd   = bus_write ? 4'd10 : 4'd4;
      wd    = bus_wdata & word_mask(idx32);
      rd    = st_rdata;
    end else if (in_map(a, 32'h1F00)) begin
      idx32 = (a - 32'h1F00) >> 2;
      cmd   = bus_write ? 4'd11 : 4'd0;
      wd    = bus_wdata & word_mask(idx32);
    end else if (a == 32'h1CDC || a == 32'h1DDC || a == 32'h1EDC || a == 32'h1FDC ||
                 a == 32'h2000 || a == 32'h2004) begin
      idx32 = num >> 5;
      wd    = 32'd1 << num[4:0];
      if (bus_write && num_ok) begin
        case (a)
          32'h1DDC: cmd = 4'd9;
          32'h1EDC: cmd = 4'd10;
          32'h1FDC: cmd = 4'd11;
          default:  cmd = 4'd8;
        endcase
      end
    end else if (is_msi) begin
      rd = genmsi_q;
    end else begin
      hit = 1'b0;
    end
  end

  assign err      = (bus_size != 2'd2) || (a[1:0] != 2'd0) || !hit;
  assign acc_ok   = bus_valid && !err;
  assign st_cmd   = acc_ok ? cmd : 4'd0;
  assign st_index = (st_cmd != 4'd0) ? idx32[IDX_W-1:0] : '0;
  assign st_wdata = (st_cmd >= 4'd6) ? wd : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      scan_req  <= 1'b0;
      msg_valid <= 1'b0;
      msg_hart  <= '0;
      msg_eiid  <= '0;
      dom_ie    <= 1'b0;
      genmsi_q  <= '0;
    end else begin
      rsp_valid <= bus_valid;
      rsp_err   <= bus_valid && err;
      rsp_rdata <= (acc_ok && !bus_write) ? rd : 32'd0;
      scan_req  <= acc_ok && bus_write;
      msg_valid <= acc_ok && bus_write && is_msi;
      if (acc_ok && bus_write && is_dom) dom_ie <= bus_wdata[8];
      if (acc_ok && bus_write && is_msi) begin
        genmsi_q <= bus_wdata & 32'hFFFC_0FFF;
        msg_hart <= bus_wdata[31:18];
        msg_eiid <= bus_wdata[10:0];
      end
    end
  end
endmodule

// File: rtl/irq_reg_if_chk.sv
module irq_reg_if_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [1:0]        bus_size,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [31:0]       rsp_rdata,
  input logic [3:0]        st_cmd,
  input logic              scan_req,
  input logic              msg_valid
);
  AST_SIZE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_size != 2'd2) |=> (rsp_valid && rsp_err)); // R1
  AST_ALIGN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_addr[1:0] != 2'd0) |=> (rsp_valid && rsp_err)); // R1
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == 32'd0 && !scan_req)); // R1
  AST_CMD_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (st_cmd != 4'd0) |-> (bus_valid && bus_size == 2'd2)); // R2
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> !rsp_valid); // R2
  AST_SCAN_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    scan_req |-> (rsp_valid && $past(bus_write))); // R11
  AST_MSG_WITH_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> scan_req); // R10
endmodule

bind irq_reg_if irq_reg_if_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_size(bus_size), .bus_addr(bus_addr), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .st_cmd(st_cmd),
  .scan_req(scan_req), .msg_valid(msg_valid)
);

// File: tb/tb_irq_reg_if.sv
module tb_irq_reg_if;
  localparam int N = 64;
  localparam int AW = 14;
  localparam int IW = $clog2(N);
  localparam int NW = (N + 31) / 32;

  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0;
  logic [1:0] bus_size = 2;
  logic [AW-1:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic rsp_valid, rsp_err, dom_ie, scan_req, msg_valid;
  logic [31:0] rsp_rdata, st_wdata, st_rdata;
  logic [3:0] st_cmd;
  logic [IW-1:0] st_index;
  logic [13:0] msg_hart;
  logic [10:0] msg_eiid;

  int checks = 0, errors = 0;
  logic m_ie = 0;
  logic [31:0] m_msi = 0;

  always #5 clk = ~clk;

  function automatic logic [31:0] fake(input logic [3:0] c, input logic [IW-1:0] i);
    return 32'h5A3C_0000 ^ (32'(c) << 24) ^ (32'(i) * 32'h9E37);
  endfunction
  assign st_rdata = fake(st_cmd, st_index);

  irq_reg_if #(.NUM_IRQ(N), .ADDR_W(AW)) dut (.*);

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] vmask(input int w);
    logic [31:0] m;
    for (int b = 0; b < 32; b++) m[b] = (w * 32 + b >= 1) && (w * 32 + b < N);
    return m;
  endfunction

  task automatic access(input logic w, input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d);
    logic err = 0; logic [3:0] c = 0; int ix = 0; logic [31:0] wd = 0, rd = 0, n;
    string tag = "R1";
    if (sz != 2 || a[1:0] != 0) err = 1;
    else if (a == 0) begin tag = "R3"; rd = 32'h8000_0004 | (32'(m_ie) << 8); end
    else if (a >= 4 && a < 4 + 4 * (N - 1)) begin
      tag = "R4"; ix = (a - 4) / 4 + 1; c = w ? 6 : 1; wd = d[10] ? 0 : d & 7;
    end else if (a >= 32'h3004 && a < 32'h3004 + 4 * (N - 1)) begin
      tag = "R5"; ix = (a - 32'h3004) / 4 + 1; c = w ? 7 : 2; wd = d & 32'hFFFF_F7FF;
    end else if (a >= 32'h1C00 && a < 32'h1C00 + 4 * NW) begin
      tag = "R6"; ix = (a - 32'h1C00) / 4; c = w ? 8 : 3; wd = d & vmask(ix);
    end else if (a >= 32'h1E00 && a < 32'h1E00 + 4 * NW) begin
      tag = "R6"; ix = (a - 32'h1E00) / 4; c = w ? 10 : 4; wd = d & vmask(ix);
    end else if (a >= 32'h1D00 && a < 32'h1D00 + 4 * NW) begin
      tag = "R7"; ix = (a - 32'h1D00) / 4; c = w ? 9 : 5; wd = d & vmask(ix);
    end else if (a >= 32'h1F00 && a < 32'h1F00 + 4 * NW) begin
      tag = "R7"; ix = (a - 32'h1F00) / 4; c = w ? 11 : 0; wd = d & vmask(ix);
    end else if (a == 32'h1CDC || a == 32'h1DDC || a == 32'h1EDC || a == 32'h1FDC ||
                 a == 32'h2000 || a == 32'h2004) begin
      tag = (a == 32'h2004) ? "R9" : "R8";
      n = (a == 32'h2004) ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
      if (w && n >= 1 && n < N) begin
        ix = n / 32; wd = 32'd1 << n[4:0];
        c = (a == 32'h1DDC) ? 9 : (a == 32'h1EDC) ? 10 : (a == 32'h1FDC) ? 11 : 8;
      end
    end else if (a == 32'h3000) begin tag = "R10"; rd = m_msi; end
    else err = 1;
    if (!err && c != 0 && !w) rd = fake(c, IW'(ix));
    if (err) tag = "R1";

    @(negedge clk);
    bus_valid = 1; bus_write = w; bus_size = sz; bus_addr = AW'(a); bus_wdata = d;
    #2;
    chk(st_cmd == c, {tag, "/R2 cmd"}, 32'(st_cmd), 32'(c));
    if (c != 0) begin
      chk(st_index == IW'(ix), {tag, " index"}, 32'(st_index), 32'(ix));
      if (w) chk(st_wdata == wd, {tag, " data"}, st_wdata, wd);
    end
    @(posedge clk); #1;
    bus_valid = 0;
    chk(rsp_valid && rsp_err == err, {tag, " err"}, 32'(rsp_err), 32'(err));
    chk(rsp_rdata == ((w || err) ? 0 : rd), {tag, " rdata"}, rsp_rdata, (w || err) ? 0 : rd);
    chk(scan_req == (w && !err), "R11 scan", 32'(scan_req), 32'(w && !err));
    if (w && !err && a == 0) m_ie = d[8];
    chk(dom_ie == m_ie, "R3 ie", 32'(dom_ie), 32'(m_ie));
    chk(msg_valid == (w && !err && a == 32'h3000), "R10 msg", 32'(msg_valid), 32'(w && !err && a == 32'h3000));
    if (w && !err && a == 32'h3000) begin
      m_msi = d & 32'hFFFC_0FFF;
      chk(msg_hart == d[31:18] && msg_eiid == d[10:0], "R10 fields",
          {msg_hart, 7'd0, msg_eiid}, {d[31:18], 7'd0, d[10:0]});
    end
  endtask

  function automatic logic [31:0] rnd_addr();
    int r = $urandom_range(0, 13);
    case (r)
      0: return 0;
      1: return 4 * $urandom_range(0, N + 1);
      2: return 32'h3000 + 4 * $urandom_range(0, N + 1);
      3: return 32'h1C00 + 4 * $urandom_range(0, NW);
      4: return 32'h1D00 + 4 * $urandom_range(0, NW);
      5: return 32'h1E00 + 4 * $urandom_range(0, NW);
      6: return 32'h1F00 + 4 * $urandom_range(0, NW);
      7: return 32'h1CDC;
      8: return 32'h1DDC;
      9: return 32'h1EDC;
      10: return 32'h1FDC;
      11: return 32'h2000 + 4 * $urandom_range(0, 1);
      12: return 32'h3FFC;
      default: return $urandom_range(0, 32'h3FFF);
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk(!rsp_valid && !rsp_err && !scan_req && !msg_valid && !dom_ie, "R12 reset", 0, 0);
    rst_n = 1;
    access(0, 2, 32'h3000, 0);
    access(0, 2, 32'h0000, 0);
    access(1, 2, 32'h0000, 32'hFFFF_FFFF);
    access(0, 2, 32'h0000, 0);
    access(1, 2, 32'h0000, 32'h0000_0100);
    access(1, 2, 32'h0004, 32'h0000_0407);
    access(1, 2, 32'h0004, 32'h0000_00FE);
    access(1, 2, 32'h0000 + 4 * (N - 1), 5);
    access(1, 2, 32'h0004 + 4 * (N - 1), 5);
    access(1, 2, 32'h3004 + 4 * (N - 2), 32'hFFFF_FFFF);
    access(1, 2, 32'h1C00, 32'hFFFF_FFFF);
    access(1, 2, 32'h1E04, 32'hFFFF_FFFF);
    access(0, 2, 32'h1D04, 0);
    access(0, 2, 32'h1F00, 0);
    access(1, 2, 32'h1C00 + 4 * NW, 1);
    access(1, 2, 32'h1CDC, 0);
    access(1, 2, 32'h1EDC, N - 1);
    access(1, 2, 32'h1FDC, N);
    access(0, 2, 32'h1DDC, 0);
    access(1, 2, 32'h2004, 32'h2100_0000);
    access(1, 2, 32'h2004, 32'h0000_0021);
    access(1, 2, 32'h3000, 32'hFFFF_FFFF);
    access(0, 2, 32'h3000, 0);
    access(1, 1, 32'h0004, 1);
    access(1, 2, 32'h0006, 1);
    access(0, 0, 32'h1C00, 0);
    access(1, 2, 32'h3FFC, 1);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a = rnd_addr();
      logic [1:0] sz = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(0, 3)) : 2'd2;
      logic [31:0] d = $urandom_range(0, 3) == 0 ? 32'($urandom_range(0, N + 3)) : $urandom();
      if ($urandom_range(0, 11) == 0) a = a | 32'($urandom_range(1, 3));
      access(1'($urandom_range(0, 1)), sz, a, d);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule